// File: doc/BRIEF.md
# Transmit Interrupt Status Unit

This block gathers the error and stall events reported by a MAC's transmit DMA engine, keeps each one in a sticky status flag, and combines the enabled flags into a single transmit interrupt line. It watches three single-cycle event inputs: a bus error returned on a DMA memory access, a missing transmit descriptor, and a collision. The collision input only counts as a late collision when the link runs half-duplex and the frame byte counter has already passed 64.

Software reaches the block through a small word-wide register port. One address reads the status flags and clears them by writing 1. A second address holds the per-source interrupt enable mask. A third address is a start-demand register: any write to it releases the DMA halt flag. The block raises the halt flag whenever a missing-descriptor event arrives.

Top module: `txirq_unit`

## Requirements
- R1: A pulse on `ev_bus_err` sets status bit 24 on the next clock edge.
- R2: A pulse on `ev_no_desc` sets status bit 23 and raises `dma_halt` on the same next clock edge.
- R3: `dma_halt` stays high until a write to address 2 (start demand), whatever the written value. It drops at the edge that takes the write. Clearing status bit 23 does not release it.
- R4: A pulse on `ev_collision` while `half_duplex` is 1 sets status bit 22 only when `frame_bytes` is greater than 64. At a count of 64 or less the bit is not set.
- R5: While `half_duplex` is 0, `ev_collision` never sets status bit 22.
- R6: A write to address 0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R7: When a set event and a write-1 clear reach the same status bit in the same cycle, the bit ends up 1.
- R8: The mask register (address 1, enables at bits 24:22 matching the status bits) resets to 0. `tx_irq` is a register that, one cycle after the status and mask change, equals the OR of status AND mask over bits 24:22.
- R9: A read (`reg_rd` high) loads `reg_rdata` at the next edge: address 0 gives status, address 1 gives mask, and any other address gives 0. All bits outside 24:22 read 0.
- R10: Reset clears all status bits, the mask, `dma_halt`, `tx_irq` and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bus_err | input | 1 | DMA access got an error response (pulse) |
| ev_no_desc | input | 1 | No transmit descriptor available (pulse) |
| ev_collision | input | 1 | Collision seen on the medium (pulse) |
| half_duplex | input | 1 | 1 when the link runs half-duplex |
| frame_bytes | input | CNT_W | Bytes of the current frame already sent |
| reg_addr | input | ADDR_W | Register select: 0 status, 1 mask, 2 start demand |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| tx_irq | output | 1 | Combined transmit interrupt |
| dma_halt | output | 1 | Tells the DMA to stay halted |

## Verification
If a status flag is wrong inside the block, the fault shows at the ports two ways. A status read shows it one edge after the read strobe. With that source enabled, `tx_irq` shows it one edge after the flag changes. A halt latch stuck in the wrong state shows on `dma_halt` right after the edge that takes the event or the start-demand write. The bench therefore checks `dma_halt` right after each such write and holds it across idle cycles. A bad late-collision qualifier shows as a wrong status bit 22 after collisions at counts just below, at and above the 64-byte limit, in both duplex modes.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
  // Number of event sources kept as sticky status flags
  localparam int NUM_SRC = 3;
  // Bit positions inside the status/mask words (software decodes these)
  localparam int POS_LATE  = 22;
  localparam int POS_NODSC = 23;
  localparam int POS_BUSER = 24;
  // Index of each source inside the packed internal vector
  localparam int IDX_LATE  = 0;
  localparam int IDX_NODSC = 1;
  localparam int IDX_BUSER = 2;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_DEMAND = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/txirq_latecol.sv
module txirq_latecol #(
  parameter int CNT_W      = 11,
  parameter int LATE_LIMIT = 64
) (
  input  logic             ev_collision,
  input  logic             half_duplex,
  input  logic [CNT_W-1:0] frame_bytes,
  output logic             late_evt
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LATE_LIMIT);

  logic past_window;

  always_comb begin
    past_window = (frame_bytes > LIMIT_C);
    late_evt    = ev_collision && half_duplex && past_window;
  end
endmodule

// File: rtl/txirq_flag.sv
module txirq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(q_o)); // R6
endmodule

// File: rtl/txirq_regport.sv
module txirq_regport
  import txirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               demand_o,
  output logic [DATA_W-1:0]  reg_rdata
);
  logic hit_status, hit_mask, hit_demand;
  logic [NUM_SRC-1:0] wfield;
  logic [DATA_W-1:0]  rd_d;
  logic unused_wdata;

  assign wfield       = reg_wdata[POS_LATE +: NUM_SRC];
  assign unused_wdata = ^{reg_wdata[DATA_W-1:POS_LATE+NUM_SRC], reg_wdata[POS_LATE-1:0]};

  always_comb begin
    hit_status = (reg_addr == ADDR_W'(SEL_STATUS));
    hit_mask   = (reg_addr == ADDR_W'(SEL_MASK));
    hit_demand = (reg_addr == ADDR_W'(SEL_DEMAND));
    clr_o      = (reg_wr && hit_status) ? wfield : '0;
    demand_o   = reg_wr && hit_demand;
  end

  always_comb begin
    rd_d = '0;
    if (hit_status)    rd_d[POS_LATE +: NUM_SRC] = status_i;
    else if (hit_mask) rd_d[POS_LATE +: NUM_SRC] = mask_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && hit_mask) mask_o <= wfield;
      if (reg_rd)             reg_rdata <= rd_d;
    end
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> (reg_rdata[DATA_W-1:POS_LATE+NUM_SRC] == '0)); // R9
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && hit_mask) |=> $stable(mask_o)); // R8
endmodule

// File: rtl/txirq_unit.sv
module txirq_unit
  import txirq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int CNT_W      = 11,
  parameter int LATE_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_bus_err,
  input  logic              ev_no_desc,
  input  logic              ev_collision,
  input  logic              half_duplex,
  input  logic [CNT_W-1:0]  frame_bytes,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_irq,
  output logic              dma_halt
);
  logic               late_evt;
  logic [NUM_SRC-1:0] set_vec, clr_vec, stat_q, mask_q;
  logic               demand;

  txirq_latecol #(.CNT_W(CNT_W), .LATE_LIMIT(LATE_LIMIT)) u_late (
    .ev_collision(ev_collision),
    .half_duplex (half_duplex),
    .frame_bytes (frame_bytes),
    .late_evt    (late_evt)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[IDX_LATE]  = late_evt;
    set_vec[IDX_NODSC] = ev_no_desc;
    set_vec[IDX_BUSER] = ev_bus_err;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    txirq_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set_i(set_vec[g]),
      .clr_i(clr_vec[g]),
      .q_o  (stat_q[g])
    );
  end

  txirq_regport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_wdata(reg_wdata),
    .status_i (stat_q),
    .mask_o   (mask_q),
    .clr_o    (clr_vec),
    .demand_o (demand),
    .reg_rdata(reg_rdata)
  );

  // Halt latch: a new descriptor-unavailable event takes precedence over a
  // start demand arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)             dma_halt <= 1'b0;
    else if (ev_no_desc) dma_halt <= 1'b1;
    else if (demand)     dma_halt <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) tx_irq <= 1'b0;
    else     tx_irq <= |(stat_q & mask_q);
  end

  AST_BUSERR_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_bus_err |=> stat_q[IDX_BUSER]); // R1
  AST_HALT_RAISE: assert property (@(posedge clk) disable iff (rst)
    ev_no_desc |=> (dma_halt && stat_q[IDX_NODSC])); // R2
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dma_halt && !(reg_wr && reg_addr == ADDR_W'(SEL_DEMAND))) |=> dma_halt); // R3
  AST_EARLY_COL: assert property (@(posedge clk) disable iff (rst)
    (ev_collision && frame_bytes <= CNT_W'(LATE_LIMIT) && !stat_q[IDX_LATE]) |=> !stat_q[IDX_LATE]); // R4
  AST_FULL_DUPLEX: assert property (@(posedge clk) disable iff (rst)
    (ev_collision && !half_duplex && !stat_q[IDX_LATE]) |=> !stat_q[IDX_LATE]); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> !tx_irq); // R8
endmodule

// File: tb/tb_txirq_unit.sv
`timescale 1ns/1ps
module tb_txirq_unit;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = 11;
  localparam logic [31:0] ALL3 = 32'h01C0_0000;

  // vector: [31:29] events {bus,nodesc,col}, [28] half_duplex,
  //         [27:12] frame bytes, [11:3] spare, [2:0] expected {b24,b23,b22}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {3'b100, 1'b1, 16'd10,   9'd0, 3'b100},
    {3'b010, 1'b1, 16'd10,   9'd0, 3'b010},
    {3'b001, 1'b1, 16'd65,   9'd0, 3'b001},
    {3'b001, 1'b1, 16'd64,   9'd0, 3'b000},
    {3'b001, 1'b0, 16'd200,  9'd0, 3'b000},
    {3'b001, 1'b1, 16'd1500, 9'd0, 3'b001},
    {3'b111, 1'b1, 16'd100,  9'd0, 3'b111},
    {3'b001, 1'b1, 16'd0,    9'd0, 3'b000},
    {3'b111, 1'b0, 16'd900,  9'd0, 3'b110}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_bus_err = 0, ev_no_desc = 0, ev_collision = 0, half_duplex = 0;
  logic [CNT_W-1:0]  frame_bytes = '0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic tx_irq, dma_halt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  txirq_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LATE_LIMIT(64)) dut (
    .clk(clk), .rst(rst),
    .ev_bus_err(ev_bus_err), .ev_no_desc(ev_no_desc), .ev_collision(ev_collision),
    .half_duplex(half_duplex), .frame_bytes(frame_bytes),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_irq(tx_irq), .dma_halt(dma_halt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [2:0] ev, input logic hd, input int bytes);
    ev_bus_err = ev[2]; ev_no_desc = ev[1]; ev_collision = ev[0];
    half_duplex = hd; frame_bytes = CNT_W'(bytes);
    @(negedge clk);
    ev_bus_err = 0; ev_no_desc = 0; ev_collision = 0;
  endtask

  task automatic clean();
    wr(2'd0, ALL3);
    wr(2'd2, 32'h0);
    step(1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    step(3);
    rst = 1'b0;
    step(1);
    // R10 reset state
    chk("R10 irq after reset", {31'd0, tx_irq}, 32'd0);
    chk("R10 halt after reset", {31'd0, dma_halt}, 32'd0);
    chk("R10 rdata after reset", reg_rdata, 32'd0);
    rd(2'd0, d); chk("R10 status after reset", d, 32'd0);
    rd(2'd1, d); chk("R8 mask resets to zero", d, 32'd0);

    // R8 masked by default: event sets status but no interrupt
    pulse(3'b100, 1'b1, 5);
    step(2);
    chk("R8 irq masked at reset", {31'd0, tx_irq}, 32'd0);
    rd(2'd0, d); chk("R1 bus error bit", d, 32'h0100_0000);
    clean();

    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R9 mask readback", d, ALL3);

    // table walk: R1 R2 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      pulse(v[31:29], v[28], int'(v[27:12]));
      chk($sformatf("R2 halt vec %0d", i), {31'd0, dma_halt}, {31'd0, v[1]});
      step(1);
      chk($sformatf("R8 irq vec %0d", i), {31'd0, tx_irq}, {31'd0, |v[2:0]});
      rd(2'd0, d);
      chk($sformatf("R1 R4 R5 status vec %0d", i), d, {7'd0, v[2:0], 22'd0});
      clean();
    end

    // R6 write-0 keeps, write-1 clears only selected bit
    pulse(3'b110, 1'b1, 0);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R6 write zero keeps", d, 32'h0180_0000);
    wr(2'd0, 32'h0100_0000);
    rd(2'd0, d); chk("R6 write one clears bit 24 only", d, 32'h0080_0000);
    clean();

    // R7 set beats clear in the same cycle
    ev_bus_err = 1'b1;
    wr(2'd0, 32'h0100_0000);
    ev_bus_err = 1'b0;
    rd(2'd0, d); chk("R7 set wins over clear", d, 32'h0100_0000);
    clean();

    // R3 halt hold and release
    pulse(3'b010, 1'b1, 0);
    step(5);
    chk("R3 halt held while idle", {31'd0, dma_halt}, 32'd1);
    wr(2'd0, 32'h0080_0000);
    chk("R3 status clear does not release", {31'd0, dma_halt}, 32'd1);
    wr(2'd1, 32'h0);
    chk("R3 mask write does not release", {31'd0, dma_halt}, 32'd1);
    wr(2'd2, 32'hDEAD_BEEF);
    chk("R3 demand releases halt", {31'd0, dma_halt}, 32'd0);
    pulse(3'b010, 1'b1, 0);
    wr(2'd2, 32'h0);
    chk("R3 demand value zero releases", {31'd0, dma_halt}, 32'd0);
    clean();

    // R8 selective mask
    wr(2'd1, 32'h0080_0000);
    pulse(3'b100, 1'b1, 0);
    pulse(3'b001, 1'b1, 300);
    step(1);
    chk("R8 unmasked sources only", {31'd0, tx_irq}, 32'd0);
    pulse(3'b010, 1'b1, 0);
    step(1);
    chk("R8 enabled source raises irq", {31'd0, tx_irq}, 32'd1);
    wr(2'd0, 32'h0080_0000);
    step(1);
    chk("R8 irq drops after clear", {31'd0, tx_irq}, 32'd0);
    rd(2'd0, d); chk("R8 other bits still set", d, 32'h0140_0000);

    // R9 unmapped address and all-set readback
    rd(2'd3, d); chk("R9 unmapped reads zero", d, 32'd0);
    pulse(3'b111, 1'b1, 70);
    rd(2'd0, d); chk("R9 only bits 24:22 read", d, ALL3);

    // R10 reset mid-run
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    chk("R10 halt cleared by reset", {31'd0, dma_halt}, 32'd0);
    rd(2'd0, d); chk("R10 status cleared by reset", d, 32'd0);
    rd(2'd1, d); chk("R10 mask cleared by reset", d, 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule